// File: doc/BRIEF.md
# Flash Page Update Engine

This block is a sequencer that sits between a client and a flash controller whose only destructive operation is erasing a whole page. It takes four commands: write a single byte, write a run of bytes that lies inside one page, erase a page, and copy a run of bytes from flash into a staging RAM. For every write it first reads the target bytes and compares them with the new data. It then decides whether the page must be erased. If so, it runs the read-back, erase and reprogram steps itself, so the client sees byte-level update semantics.

When an erase is needed, the bytes of the page that the write does not cover are handled in one of three ways. They can be kept, by saving them into the staging RAM before the erase and programming them back afterwards. They can be dropped, leaving them erased. Or, in force mode, every run write erases first and drops them. The staging RAM doubles as the page image. For a run write, the byte meant for page offset k sits at RAM address base+k, so the window must be a full page long. Flash traffic goes through a request/acknowledge port, and the RAM is read combinationally.

Top module: `fpue`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `busy`, `done`, `err`, `fl_req` and `ram_we` are 0.
- R2: A single-byte write (`cmd_op`=0, data on `cmd_byte`, `cmd_len` ignored) whose new value sets no bit that is 0 in flash issues no erase. The target byte becomes the new value and the rest of flash is unchanged.
- R3: A single-byte write that needs any bit to go from 0 to 1 erases its page exactly once and reprograms every other byte of that page with its old value, whatever `cmd_mode` holds. The staging window then holds those old values at their page offsets.
- R4: A run write (`cmd_op`=1) in keep mode (`cmd_mode`=0) that needs an erase erases once. Covered bytes take the RAM values at base+offset, and uncovered bytes keep their old values, which are also left in the staging window. This includes a run that covers a full page.
- R5: In drop mode (`cmd_mode`=1), a run write that needs an erase leaves uncovered bytes at 0xFF. One that needs no erase programs only the covered bytes and leaves the rest unchanged.
- R6: In force mode (`cmd_mode`=2 or 3), every run write erases once, even if no bit must rise, and uncovered bytes end at 0xFF.
- R7: A run write with page offset plus count greater than the page size performs no flash operation and finishes with `err` high during the `done` cycle. A run that ends exactly at the page end is accepted.
- R8: A page erase (`cmd_op`=2) given any address in a page sets that whole page to 0xFF with one erase request at the page's first address, and no other page changes.
- R9: A copy (`cmd_op`=3) of N bytes, 1 to 256, writes flash address A+i, modulo the flash size, to RAM address base+i, crossing page boundaries freely.
- R10: `busy` rises in the cycle after a command is accepted and stays high through the single cycle in which `done` is high. Commands presented while `busy` is high are ignored.
- R11: Once `fl_req` is raised, it stays high with `fl_op` (0 read, 1 program, 2 erase), `fl_addr` and `fl_wdata` unchanged until the cycle in which `fl_ack` is high.
- R12: A run write or a copy with `cmd_len`=0 completes with `done`, without `err` and without any flash operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | 0 byte write, 1 run write, 2 page erase, 3 copy to RAM |
| cmd_mode | input | 2 | Uncovered-byte policy for run writes: 0 keep, 1 drop, 2/3 force erase |
| cmd_faddr | input | ADDR_W | Flash byte address (start of run) |
| cmd_raddr | input | RAM_AW | Staging RAM base address |
| cmd_len | input | 9 | Byte count, 0 to 256 |
| cmd_byte | input | 8 | Data for a single-byte write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected command, valid with done |
| fl_req | output | 1 | Flash request |
| fl_op | output | 2 | Flash operation code |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Program data |
| fl_ack | input | 1 | Flash acknowledge, one cycle |
| fl_rdata | input | 8 | Read data, valid with fl_ack |
| ram_addr | output | RAM_AW | Staging RAM address |
| ram_we | output | 1 | Staging RAM write enable |
| ram_wdata | output | 8 | Staging RAM write data |
| ram_rdata | input | 8 | Staging RAM read data, same cycle |

## Verification
The bench builds the engine with 16-byte pages, an 8-bit flash address giving sixteen pages, and a 256-byte staging RAM. With pages this small, every full-page sweep of the save and reprogram loops finishes in a few dozen cycles. A run can be placed to end exactly at a page end or one past it. A maximum-length copy of 256 bytes wraps across every page and around the flash address space. Each mode is driven both with data that forces an erase and with data that does not, so the erase decision and the fate of uncovered bytes are both observed.

// File: rtl/fpue_pkg.sv
package fpue_pkg;

   localparam int LEN_W = 9;

   typedef enum logic [1:0] {
      CMD_WR_BYTE = 2'd0,
      CMD_WR_RUN  = 2'd1,
      CMD_ERASE   = 2'd2,
      CMD_READ    = 2'd3
   } fpue_cmd_e;

   typedef enum logic [1:0] {
      FOP_READ  = 2'd0,
      FOP_PROG  = 2'd1,
      FOP_ERASE = 2'd2
   } fpue_fop_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_STAGE,
      ST_CHECK,
      ST_SAVE,
      ST_ERASE,
      ST_PROG,
      ST_COPY,
      ST_FINISH
   } fpue_state_e;

   localparam logic [1:0] MODE_KEEP = 2'd0;

endpackage

// File: rtl/fpue_span.sv
module fpue_span #(
   parameter int PAGE_BYTES = 64,
   parameter int OFF_W      = 6,
   parameter int LEN_W      = 9
) (
   input  logic [OFF_W-1:0] start,
   input  logic [LEN_W-1:0] len,
   input  logic [LEN_W-1:0] idx,
   output logic             covered,
   output logic             crosses,
   output logic [LEN_W-1:0] last_idx
);
   localparam int SUM_W = LEN_W + 1;

   logic [SUM_W-1:0] end_x;

   assign end_x    = SUM_W'(start) + SUM_W'(len);
   assign crosses  = end_x > SUM_W'(PAGE_BYTES);
   assign covered  = (SUM_W'(idx) >= SUM_W'(start)) && (SUM_W'(idx) < end_x);
   assign last_idx = LEN_W'(end_x - SUM_W'(1));

endmodule

// File: rtl/fpue_need_erase.sv
module fpue_need_erase #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] old_v,
   input  logic [DATA_W-1:0] new_v,
   output logic              need
);
   // a bit that must rise from 0 to 1 cannot be programmed
   assign need = |(new_v & ~old_v);

endmodule

// File: rtl/fpue_page_base.sv
module fpue_page_base #(
   parameter int ADDR_W = 12,
   parameter int OFF_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] base
);
   generate
      if (ADDR_W > OFF_W) begin : g_paged
         assign base = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end else begin : g_single
         logic unused_addr;
         assign unused_addr = ^addr;
         assign base = '0;
      end
   endgenerate

endmodule

// File: rtl/fpue.sv
module fpue #(
   parameter int ADDR_W     = 12,
   parameter int PAGE_BYTES = 64,
   parameter int RAM_AW     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [1:0]        cmd_mode,
   input  logic [ADDR_W-1:0] cmd_faddr,
   input  logic [RAM_AW-1:0] cmd_raddr,
   input  logic [8:0]        cmd_len,
   input  logic [7:0]        cmd_byte,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              fl_req,
   output logic [1:0]        fl_op,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_wdata,
   input  logic              fl_ack,
   input  logic [7:0]        fl_rdata,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_we,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata
);
   import fpue_pkg::*;

   localparam int OFF_W = $clog2(PAGE_BYTES);
   localparam logic [LEN_W-1:0] LAST_OFF = LEN_W'(PAGE_BYTES - 1);

   initial begin
      assert (PAGE_BYTES >= 2 && PAGE_BYTES <= 256 && (PAGE_BYTES & (PAGE_BYTES - 1)) == 0)
         else $error("PAGE_BYTES must be a power of two from 2 to 256");
      assert (ADDR_W >= OFF_W) else $error("ADDR_W must hold at least one page");
      assert (RAM_AW >= OFF_W) else $error("staging RAM must hold a full page");
   end

   fpue_state_e       st;
   logic [1:0]        op_q;
   logic              keep_q;
   logic              need_q;
   logic              err_q;
   logic [ADDR_W-1:0] faddr_q;
   logic [RAM_AW-1:0] raddr_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  cnt;
   logic [7:0]        byte_q;

   logic              idle;
   logic [OFF_W-1:0]  sp_start;
   logic [LEN_W-1:0]  sp_len;
   logic              sp_covered;
   logic              sp_crosses;
   logic [LEN_W-1:0]  sp_last;
   logic              need_hit;
   logic [ADDR_W-1:0] page_base;
   logic              prog_sel;

   assign idle     = (st == ST_IDLE);
   assign sp_start = idle ? cmd_faddr[OFF_W-1:0] : faddr_q[OFF_W-1:0];
   assign sp_len   = idle ? cmd_len : len_q;
   assign prog_sel = sp_covered || (need_q && keep_q);

   fpue_span #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_span (
      .start    (sp_start),
      .len      (sp_len),
      .idx      (cnt),
      .covered  (sp_covered),
      .crosses  (sp_crosses),
      .last_idx (sp_last)
   );

   fpue_need_erase #(.DATA_W(8)) u_need (
      .old_v (fl_rdata),
      .new_v (ram_rdata),
      .need  (need_hit)
   );

   fpue_page_base #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pbase (
      .addr (faddr_q),
      .base (page_base)
   );

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         op_q    <= '0;
         keep_q  <= 1'b0;
         need_q  <= 1'b0;
         err_q   <= 1'b0;
         faddr_q <= '0;
         raddr_q <= '0;
         len_q   <= '0;
         cnt     <= '0;
         byte_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_q    <= cmd_op;
                  faddr_q <= cmd_faddr;
                  raddr_q <= cmd_raddr;
                  byte_q  <= cmd_byte;
                  len_q   <= cmd_len;
                  cnt     <= '0;
                  err_q   <= 1'b0;
                  keep_q  <= (cmd_mode == MODE_KEEP) || (cmd_op == CMD_WR_BYTE);
                  need_q  <= cmd_mode[1] && (cmd_op == CMD_WR_RUN);
                  case (cmd_op)
                     CMD_WR_BYTE: begin
                        len_q <= LEN_W'(1);
                        st    <= ST_STAGE;
                     end
                     CMD_WR_RUN: begin
                        if (cmd_len == '0) begin
                           st <= ST_FINISH;
                        end else if (sp_crosses) begin
                           err_q <= 1'b1;
                           st    <= ST_FINISH;
                        end else if (cmd_mode[1]) begin
                           st <= ST_ERASE;
                        end else begin
                           cnt <= LEN_W'(cmd_faddr[OFF_W-1:0]);
                           st  <= ST_CHECK;
                        end
                     end
                     CMD_ERASE: st <= ST_ERASE;
                     default:   st <= (cmd_len == '0) ? ST_FINISH : ST_COPY;
                  endcase
               end
            end
            ST_STAGE: begin
               cnt <= LEN_W'(faddr_q[OFF_W-1:0]);
               st  <= ST_CHECK;
            end
            ST_CHECK: begin
               if (fl_ack) begin
                  if (need_hit) begin
                     need_q <= 1'b1;
                     cnt    <= '0;
                     st     <= keep_q ? ST_SAVE : ST_ERASE;
                  end else if (cnt == sp_last) begin
                     cnt <= '0;
                     st  <= ST_PROG;
                  end else begin
                     cnt <= cnt + LEN_W'(1);
                  end
               end
            end
            ST_SAVE: begin
               if (sp_covered || fl_ack) begin
                  if (cnt == LAST_OFF) begin
                     cnt <= '0;
                     st  <= ST_ERASE;
                  end else begin
                     cnt <= cnt + LEN_W'(1);
                  end
               end
            end
            ST_ERASE: begin
               if (fl_ack) begin
                  cnt <= '0;
                  st  <= (op_q == CMD_ERASE) ? ST_FINISH : ST_PROG;
               end
            end
            ST_PROG: begin
               if (!prog_sel || fl_ack) begin
                  if (cnt == LAST_OFF) st <= ST_FINISH;
                  else                 cnt <= cnt + LEN_W'(1);
               end
            end
            ST_COPY: begin
               if (fl_ack) begin
                  if (cnt == len_q - LEN_W'(1)) st <= ST_FINISH;
                  else                          cnt <= cnt + LEN_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // flash and RAM port drive
   always_comb begin
      fl_req    = 1'b0;
      fl_op     = FOP_READ;
      fl_addr   = page_base | ADDR_W'(cnt[OFF_W-1:0]);
      fl_wdata  = ram_rdata;
      ram_addr  = raddr_q + RAM_AW'(cnt);
      ram_we    = 1'b0;
      ram_wdata = fl_rdata;
      case (st)
         ST_STAGE: begin
            ram_addr  = raddr_q + RAM_AW'(faddr_q[OFF_W-1:0]);
            ram_we    = 1'b1;
            ram_wdata = byte_q;
         end
         ST_CHECK: fl_req = 1'b1;
         ST_SAVE: begin
            fl_req = !sp_covered;
            ram_we = fl_ack;
         end
         ST_ERASE: begin
            fl_req  = 1'b1;
            fl_op   = FOP_ERASE;
            fl_addr = page_base;
         end
         ST_PROG: begin
            fl_req = prog_sel;
            fl_op  = FOP_PROG;
         end
         ST_COPY: begin
            fl_req  = 1'b1;
            fl_addr = faddr_q + ADDR_W'(cnt);
            ram_we  = fl_ack;
         end
         default: ;
      endcase
   end

   assign busy = !idle;
   assign done = (st == ST_FINISH);
   assign err  = done && err_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && !fl_ack |=> fl_req && $stable(fl_op) && $stable(fl_addr) && $stable(fl_wdata)); // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !busy |=> busy); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !fl_req && !ram_we); // R1
   AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done && !fl_req); // R7
   AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && fl_op == FOP_ERASE |-> fl_addr[OFF_W-1:0] == '0); // R8

endmodule

// File: tb/fpue_bench.sv
module fpue_bench;
   import fpue_pkg::*;

   localparam int AW  = 8;
   localparam int PG  = 16;
   localparam int RW  = 8;
   localparam int FSZ = 256;
   localparam int RSZ = 256;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          cmd_valid;
   logic [1:0]    cmd_op, cmd_mode;
   logic [AW-1:0] cmd_faddr;
   logic [RW-1:0] cmd_raddr;
   logic [8:0]    cmd_len;
   logic [7:0]    cmd_byte;
   logic          busy, done, err;
   logic          fl_req, fl_ack;
   logic [1:0]    fl_op;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_wdata, fl_rdata;
   logic [RW-1:0] ram_addr;
   logic          ram_we;
   logic [7:0]    ram_wdata, ram_rdata;

   fpue #(.ADDR_W(AW), .PAGE_BYTES(PG), .RAM_AW(RW)) u_fpue (
      .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_mode, .cmd_faddr, .cmd_raddr,
      .cmd_len, .cmd_byte, .busy, .done, .err, .fl_req, .fl_op, .fl_addr,
      .fl_wdata, .fl_ack, .fl_rdata, .ram_addr, .ram_we, .ram_wdata, .ram_rdata
   );

   // flash model: program ANDs, erase fills a page with 0xFF
   logic [7:0]    fmem [FSZ];
   int            n_ops, n_erase, n_hold_viol;
   logic          prv_wait;
   logic [1:0]    prv_op;
   logic [AW-1:0] prv_addr;
   logic [7:0]    prv_wd;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < FSZ; i++) fmem[i] <= 8'((i * 37) + 5);
         fl_ack <= 1'b0; fl_rdata <= '0;
         n_ops <= 0; n_erase <= 0; n_hold_viol <= 0; prv_wait <= 1'b0;
      end else begin
         if (prv_wait && !(fl_req && fl_op == prv_op && fl_addr == prv_addr && fl_wdata == prv_wd))
            n_hold_viol <= n_hold_viol + 1;
         prv_wait <= fl_req && !fl_ack;
         prv_op <= fl_op; prv_addr <= fl_addr; prv_wd <= fl_wdata;
         fl_ack <= 1'b0;
         if (fl_req && !fl_ack) begin
            fl_ack <= 1'b1;
            n_ops  <= n_ops + 1;
            case (fl_op)
               2'd0: fl_rdata <= fmem[fl_addr];
               2'd1: fmem[fl_addr] <= fmem[fl_addr] & fl_wdata;
               default: begin
                  n_erase <= n_erase + 1;
                  for (int k = 0; k < PG; k++) fmem[(int'(fl_addr) & ~(PG - 1)) + k] <= 8'hFF;
               end
            endcase
         end
      end
   end

   // staging RAM model with a bench load port
   logic [7:0]    ram [RSZ];
   logic          tb_we;
   logic [RW-1:0] tb_a;
   logic [7:0]    tb_d;
   assign ram_rdata = ram[ram_addr];
   always @(posedge clk) begin
      if (ram_we)     ram[ram_addr] <= ram_wdata;
      else if (tb_we) ram[tb_a]     <= tb_d;
   end

   // scoreboard
   typedef struct {
      bit    err;
      int    erases;
      bit    quiet;
      string req;
   } exp_t;
   exp_t sbq[$];
   int   snap_ops, snap_erase;
   int   n_tests, n_fail, mon_tests, mon_fail, wd_fail;
   exp_t mon_e;

   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sbq.size() == 0) begin
            mon_tests++; mon_fail++;
            $display("FAIL R10 unexpected done: actual 1 expected 0");
         end else begin
            mon_e = sbq.pop_front();
            mon_tests++;
            if (err !== mon_e.err) begin
               mon_fail++;
               $display("FAIL %s err: actual %0d expected %0d", mon_e.req, err, mon_e.err);
            end
            mon_tests++;
            if (n_erase - snap_erase != mon_e.erases) begin
               mon_fail++;
               $display("FAIL %s erase count: actual %0d expected %0d", mon_e.req,
                        n_erase - snap_erase, mon_e.erases);
            end
            if (mon_e.quiet) begin
               mon_tests++;
               if (n_ops != snap_ops) begin
                  mon_fail++;
                  $display("FAIL %s flash ops: actual %0d expected 0", mon_e.req, n_ops - snap_ops);
               end
            end
         end
      end
   end

   logic [7:0] gmem [FSZ];
   logic [7:0] stage_exp [PG];
   bit         stage_chk;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic ram_put(int a, logic [7:0] d);
      @(negedge clk); tb_we = 1'b1; tb_a = RW'(a); tb_d = d;
      @(negedge clk); tb_we = 1'b0;
   endtask

   task automatic start_cmd(logic [1:0] op, int fa, int ra, int len, logic [7:0] bt,
                            logic [1:0] md, exp_t e);
      sbq.push_back(e);
      @(negedge clk);
      snap_ops = n_ops; snap_erase = n_erase;
      cmd_op = op; cmd_faddr = AW'(fa); cmd_raddr = RW'(ra); cmd_len = 9'(len);
      cmd_byte = bt; cmd_mode = md; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b1, "R10", "busy after accept", int'(busy), 1);
   endtask

   task automatic wait_cmd();
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(!done && !busy, "R10", "done lasts one cycle", int'({done, busy}), 0);
   endtask

   task automatic check_flash(string req);
      int bad = -1;
      for (int i = 0; i < FSZ; i++) if (fmem[i] !== gmem[i] && bad < 0) bad = i;
      if (bad >= 0) $display("  mismatch at flash address %0h", bad);
      chk(bad < 0, req, "flash image", bad < 0 ? 0 : int'(fmem[bad]), bad < 0 ? 0 : int'(gmem[bad]));
   endtask

   // golden model of a write, built from the requirements
   task automatic gold_write(int fa, int ra, int len, logic [7:0] bt, bit is_byte,
                             logic [1:0] md, output int erases);
      int pb = fa & ~(PG - 1);
      int s  = fa % PG;
      int l  = is_byte ? 1 : len;
      bit keep = is_byte || md == 2'd0;
      bit need = !is_byte && md[1];
      logic [7:0] nv [PG];
      for (int i = 0; i < l; i++) begin
         nv[s + i] = is_byte ? bt : ram[(ra + s + i) % RSZ];
         if ((gmem[pb + s + i] & nv[s + i]) != nv[s + i]) need = 1'b1;
      end
      stage_chk = need && keep;
      for (int k = 0; k < PG; k++) begin
         bit cov = (k >= s) && (k < s + l);
         stage_exp[k] = gmem[pb + k];
         if (cov)       gmem[pb + k] = need ? nv[k] : (gmem[pb + k] & nv[k]);
         else if (need) gmem[pb + k] = keep ? gmem[pb + k] : 8'hFF;
      end
      erases = need ? 1 : 0;
   endtask

   task automatic do_write(int fa, int ra, int len, logic [7:0] bt, bit is_byte,
                           logic [1:0] md, string req);
      exp_t e;
      int   er;
      int   bad = -1;
      int   s = fa % PG;
      int   l = is_byte ? 1 : len;
      gold_write(fa, ra, len, bt, is_byte, md, er);
      e.err = 1'b0; e.erases = er; e.quiet = 1'b0; e.req = req;
      start_cmd(is_byte ? 2'd0 : 2'd1, fa, ra, is_byte ? 0 : len, bt, md, e);
      wait_cmd();
      check_flash(req);
      if (stage_chk) begin
         for (int k = 0; k < PG; k++)
            if ((k < s || k >= s + l) && ram[(ra + k) % RSZ] !== stage_exp[k] && bad < 0) bad = k;
         chk(bad < 0, req, "staging window old value", bad < 0 ? 0 : int'(ram[(ra + bad) % RSZ]),
             bad < 0 ? 0 : int'(stage_exp[bad]));
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      wd_fail = 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests + mon_tests + 1, n_fail + mon_fail + 1);
      $finish;
   end

   initial begin : main
      exp_t e;
      int   bad;
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_mode = '0; cmd_faddr = '0;
      cmd_raddr = '0; cmd_len = '0; cmd_byte = '0; tb_we = 1'b0; tb_a = '0; tb_d = '0;
      for (int i = 0; i < FSZ; i++) gmem[i] = 8'((i * 37) + 5);
      repeat (3) @(negedge clk);
      chk(!busy && !done && !err && !fl_req && !ram_we, "R1", "outputs in reset",
          int'({busy, done, err, fl_req, ram_we}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err && !fl_req && !ram_we, "R1", "outputs after reset",
          int'({busy, done, err, fl_req, ram_we}), 0);

      // R2: byte write with no rising bit
      do_write(8'h23, 0, 0, gmem[8'h23] & 8'hF0, 1'b1, 2'd0, "R2");
      // R3: byte write needing an erase, mode ignored
      do_write(8'h25, 8'h20, 0, ~gmem[8'h25], 1'b1, 2'd2, "R3");

      // R4: run in keep mode needing an erase
      for (int i = 0; i < 5; i++) ram_put(8'h40 + 4 + i, ~gmem[8'h34 + i]);
      do_write(8'h34, 8'h40, 5, 8'h00, 1'b0, 2'd0, "R4");
      // R4: full page run
      for (int i = 0; i < PG; i++) ram_put(8'hC0 + i, ~gmem[8'h80 + i] ^ 8'h0F);
      do_write(8'h80, 8'hC0, PG, 8'h00, 1'b0, 2'd0, "R4");

      // R5: drop mode with and without erase
      for (int i = 0; i < 3; i++) ram_put(8'h60 + 2 + i, 8'hFF);
      do_write(8'h42, 8'h60, 3, 8'h00, 1'b0, 2'd1, "R5");
      for (int i = 0; i < 4; i++) ram_put(8'h60 + 7 + i, gmem[8'h57 + i] & 8'h0F);
      do_write(8'h57, 8'h60, 4, 8'h00, 1'b0, 2'd1, "R5");

      // R6: force mode with data that needs no erase
      for (int i = 0; i < 2; i++) ram_put(8'h70 + 1 + i, gmem[8'h61 + i] & 8'h3C);
      do_write(8'h61, 8'h70, 2, 8'h00, 1'b0, 2'd2, "R6");

      // R7: crossing run rejected, exact fit accepted
      e.err = 1'b1; e.erases = 0; e.quiet = 1'b1; e.req = "R7";
      start_cmd(2'd1, 8'h7C, 8'h00, 8, 8'h00, 2'd0, e);
      wait_cmd();
      check_flash("R7");
      for (int i = 0; i < 4; i++) ram_put(8'h90 + 12 + i, 8'hFF);
      do_write(8'hEC, 8'h90, 4, 8'h00, 1'b0, 2'd1, "R7");

      // R8: erase by an address in the middle of a page
      for (int k = 0; k < PG; k++) gmem[8'h90 + k] = 8'hFF;
      e.err = 1'b0; e.erases = 1; e.quiet = 1'b0; e.req = "R8";
      start_cmd(2'd2, 8'h9B, 8'h00, 0, 8'h00, 2'd0, e);
      wait_cmd();
      check_flash("R8");

      // R9: copy crossing pages, then a full 256-byte wrap
      e.err = 1'b0; e.erases = 0; e.quiet = 1'b0; e.req = "R9";
      start_cmd(2'd3, 8'hB6, 8'h80, 40, 8'h00, 2'd0, e);
      wait_cmd();
      bad = -1;
      for (int i = 0; i < 40; i++) if (ram[8'h80 + i] !== gmem[(8'hB6 + i) % FSZ] && bad < 0) bad = i;
      chk(bad < 0, "R9", "copied bytes", bad < 0 ? 0 : int'(ram[8'h80 + bad]),
          bad < 0 ? 0 : int'(gmem[(8'hB6 + bad) % FSZ]));
      start_cmd(2'd3, 8'h10, 8'h00, 256, 8'h00, 2'd0, e);
      wait_cmd();
      bad = -1;
      for (int i = 0; i < 256; i++) if (ram[i] !== gmem[(8'h10 + i) % FSZ] && bad < 0) bad = i;
      chk(bad < 0, "R9", "256-byte copy", bad < 0 ? 0 : int'(ram[bad]),
          bad < 0 ? 0 : int'(gmem[(8'h10 + bad) % FSZ]));

      // R12: zero-length run write and copy
      e.err = 1'b0; e.erases = 0; e.quiet = 1'b1; e.req = "R12";
      start_cmd(2'd1, 8'h33, 8'h00, 0, 8'h00, 2'd0, e);
      wait_cmd();
      start_cmd(2'd3, 8'h33, 8'h00, 0, 8'h00, 2'd0, e);
      wait_cmd();
      check_flash("R12");

      // R10: an erase presented while busy is ignored
      for (int i = 0; i < 3; i++) ram_put(8'h20 + 5 + i, ~gmem[8'hA5 + i]);
      begin
         int er;
         gold_write(8'hA5, 8'h20, 3, 8'h00, 1'b0, 2'd0, er);
         e.err = 1'b0; e.erases = er; e.quiet = 1'b0; e.req = "R10";
      end
      start_cmd(2'd1, 8'hA5, 8'h20, 3, 8'h00, 2'd0, e);
      cmd_op = 2'd2; cmd_faddr = 8'hC3; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_cmd();
      check_flash("R10");

      chk(n_hold_viol == 0, "R11", "request held until ack", n_hold_viol, 0);

      repeat (4) @(negedge clk);
      chk(sbq.size() == 0, "R10", "pending completions", sbq.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests + mon_tests + wd_fail,
               n_fail + mon_fail + wd_fail);
      $finish;
   end

endmodule